// File: doc/BRIEF.md
# Multi-Channel Descriptor DMA Engine

This block moves blocks of bytes between memory locations. It has several channels, and each channel keeps its own transfer descriptor. A descriptor holds a source pointer, a destination pointer, a signed step for each pointer, an access width for each side, a byte count for each activation, a current iteration count, a reload iteration count, a signed adjustment for each pointer that is applied when the whole job completes, and a small set of control and status bits. Software fills the descriptor through a register write port and then writes the start bit.

Only one channel runs at a time. Pending channels are chosen in round-robin order, counting downward. The granted channel copies its descriptor into working registers. It then moves its byte count through a single-beat read/write memory master port. Narrow source reads are gathered into a wider destination write, or a wide read is split into narrower writes.

When an activation ends, the engine writes the stepped pointers back into the descriptor and decrements the iteration count. On the final iteration the engine instead reloads the count, applies the last-adjustments, sets the done bit and, if enabled, raises a sticky interrupt.

Top module: `xfer_engine`

## Requirements
- R1: Descriptor fields are written with `cfg_we`, `cfg_ch` and `cfg_sel`, and are read back on `rd_data` using the same select codes. The codes are: 0 source pointer, 1 destination pointer, 2 source step (16-bit signed), 3 destination step, 4 sizes (bits 1:0 source, bits 3:2 destination), 5 byte count, 6 iterations (bits 15:0 current, bits 31:16 reload), 7 source last-adjust, 8 destination last-adjust, 9 control, 10 interrupt clear. A control read returns bit0 start, bit1 interrupt enable, bit2 active, bit3 done, bit4 config error, bit5 interrupt pending. After reset every field reads 0.
- R2: Writing control with bit0 set and a valid configuration sets start. When the channel is granted, start and done are cleared and active is set, all in the same cycle. At most one channel is active at a time.
- R3: Pending channels are granted in round-robin order. The search starts one below the last granted channel and moves downward, wrapping at the bottom. After reset the search starts at the highest channel.
- R4: Size code 0 is a byte, 1 is a 16-bit halfword and 2 is a 32-bit word. Narrow source reads are packed little-endian into a wide destination write: the lowest-addressed byte goes into bits 7:0.
- R5: A wide source read is split into narrow destination writes, starting with its lowest byte lane.
- R6: Each pointer steps by its own signed step after every access. Negative steps walk downward through memory.
- R7: The memory port has one access outstanding at a time. A request holds its address, size, direction and write data stable until `m_ready` is seen.
- R8: Each activation moves the full byte count and then clears active. On any iteration except the last, the current count drops by one and the stepped pointers are written back to the descriptor.
- R9: On the final iteration (current count equal to 1), the current count is reloaded from the reload count. The source and destination last-adjustments are added to the written-back pointers, and done is set.
- R10: Done raises `irq` only when the interrupt enable is set. `irq` then stays high until software writes select 10 with bit0 set.
- R11: A start is refused and the config-error bit is set if the byte count is zero, if it is not a multiple of the larger access size, or if either size code is 3. A refused start never reaches the memory port. A later accepted start clears the config-error bit.
- R12: While a channel is active, descriptor writes to that channel (selects 0 to 9) have no effect. Writes to other channels still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_ch | input | CW | Channel addressed by the write |
| cfg_sel | input | 4 | Field select for the write |
| cfg_wdata | input | 32 | Write data |
| rd_ch | input | CW | Channel addressed by the read |
| rd_sel | input | 4 | Field select for the read |
| rd_data | output | 32 | Read data (combinational) |
| m_valid | output | 1 | Memory request valid |
| m_write | output | 1 | 1 for a write, 0 for a read |
| m_addr | output | AW | Access address |
| m_size | output | 2 | Access size code |
| m_wdata | output | 32 | Write data, right-justified |
| m_ready | input | 1 | Access accepted and completed |
| m_rdata | input | 32 | Read data, right-justified |
| ch_active | output | NCH | Per-channel active bits |
| ch_done | output | NCH | Per-channel done bits |
| irq | output | 1 | OR of pending interrupts |

## Verification
The embedded assertions check several properties on every cycle:
- no more than one channel is active;
- a stalled memory request keeps its address, size, direction and data;
- memory requests appear only while a channel is active;
- done rises only in the cycle its channel's active bit falls;
- an interrupt becomes pending only together with a rising done;
- a refused start leaves start clear;
- a step field does not change under a blocked write.

Other behaviours can only be shown by the directed scenarios, because they depend on data and ordering: the byte-lane order of packed and split data, the downward pointer walk with negative steps, iteration-count reload and last-adjustment, and the exact round-robin grant order among three simultaneous requests.

// File: rtl/xfer_engine.sv
module xfer_engine #(
  parameter int NCH = 4,
  parameter int AW  = 32,
  parameter int NW  = 16,
  parameter int IW  = 16,
  parameter int CW  = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [CW-1:0] cfg_ch,
  input  logic [3:0]    cfg_sel,
  input  logic [31:0]   cfg_wdata,
  input  logic [CW-1:0] rd_ch,
  input  logic [3:0]    rd_sel,
  output logic [31:0]   rd_data,
  output logic          m_valid,
  output logic          m_write,
  output logic [AW-1:0] m_addr,
  output logic [1:0]    m_size,
  output logic [31:0]   m_wdata,
  input  logic          m_ready,
  input  logic [31:0]   m_rdata,
  output logic [NCH-1:0] ch_active,
  output logic [NCH-1:0] ch_done,
  output logic          irq
);
  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_RD, S_WR, S_FIN} state_t;

  logic [AW-1:0] sa [NCH];
  logic [AW-1:0] da [NCH];
  logic [AW-1:0] sl [NCH];
  logic [AW-1:0] dl [NCH];
  logic [15:0]   so [NCH];
  logic [15:0]   dof [NCH];
  logic [1:0]    ssz [NCH];
  logic [1:0]    dsz [NCH];
  logic [NW-1:0] nb [NCH];
  logic [IW-1:0] cit [NCH];
  logic [IW-1:0] bit_q [NCH];
  logic [NCH-1:0] st, ie, act, dn, er, ip;

  state_t        state;
  logic [CW-1:0] cur, rr_last, gnt;
  logic          found;
  logic [AW-1:0] wsa, wda;
  logic [NW-1:0] left;
  logic [2:0]    pos;
  logic [31:0]   buff, buf_nx;

  function automatic logic [2:0] chunk_of(input logic [1:0] a, input logic [1:0] b);
    logic [2:0] x, y;
    x = 3'd1 << a;
    y = 3'd1 << b;
    return (x > y) ? x : y;
  endfunction

  wire [2:0] sb  = 3'd1 << ssz[cur];
  wire [2:0] db  = 3'd1 << dsz[cur];
  wire [2:0] chk = chunk_of(ssz[cur], dsz[cur]);
  wire [AW-1:0] soff_x = {{(AW-16){so[cur][15]}}, so[cur]};
  wire [AW-1:0] doff_x = {{(AW-16){dof[cur][15]}}, dof[cur]};

  wire [2:0] cfg_chk = chunk_of(ssz[cfg_ch], dsz[cfg_ch]);
  wire cfg_ok = (ssz[cfg_ch] != 2'd3) && (dsz[cfg_ch] != 2'd3) && (nb[cfg_ch] != '0) &&
                ((nb[cfg_ch][2:0] & (cfg_chk - 3'd1)) == 3'd0);

  always_comb begin
    found = 1'b0;
    gnt   = '0;
    for (int k = 1; k <= NCH; k++) begin
      if (!found && st[CW'(rr_last - CW'(k))]) begin
        found = 1'b1;
        gnt   = CW'(rr_last - CW'(k));
      end
    end
  end

  always_comb begin
    buf_nx = buff;
    for (int j = 0; j < 4; j++)
      if (j < int'(sb) && (int'(pos) + j) < 4)
        buf_nx[(int'(pos) + j)*8 +: 8] = m_rdata[j*8 +: 8];
  end

  assign m_valid   = (state == S_RD) || (state == S_WR);
  assign m_write   = (state == S_WR);
  assign m_addr    = m_write ? wda : wsa;
  assign m_size    = m_write ? dsz[cur] : ssz[cur];
  assign m_wdata   = buff >> {pos, 3'b000};
  assign ch_active = act;
  assign ch_done   = dn;
  assign irq       = |ip;

  always_comb begin
    case (rd_sel)
      4'd0:    rd_data = 32'(sa[rd_ch]);
      4'd1:    rd_data = 32'(da[rd_ch]);
      4'd2:    rd_data = {16'd0, so[rd_ch]};
      4'd3:    rd_data = {16'd0, dof[rd_ch]};
      4'd4:    rd_data = {28'd0, dsz[rd_ch], ssz[rd_ch]};
      4'd5:    rd_data = 32'(nb[rd_ch]);
      4'd6:    rd_data = {16'(bit_q[rd_ch]), 16'(cit[rd_ch])};
      4'd7:    rd_data = 32'(sl[rd_ch]);
      4'd8:    rd_data = 32'(dl[rd_ch]);
      4'd9:    rd_data = {26'd0, ip[rd_ch], er[rd_ch], dn[rd_ch], act[rd_ch], ie[rd_ch], st[rd_ch]};
      default: rd_data = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        sa[c] <= '0; da[c] <= '0; sl[c] <= '0; dl[c] <= '0;
        so[c] <= '0; dof[c] <= '0; ssz[c] <= '0; dsz[c] <= '0;
        nb[c] <= '0; cit[c] <= '0; bit_q[c] <= '0;
      end
      st <= '0; ie <= '0; act <= '0; dn <= '0; er <= '0; ip <= '0;
      state <= S_IDLE; cur <= '0; rr_last <= '0;
      wsa <= '0; wda <= '0; left <= '0; pos <= '0; buff <= '0;
    end else begin
      if (cfg_we) begin
        if (cfg_sel == 4'd10) begin
          if (cfg_wdata[0]) ip[cfg_ch] <= 1'b0;
        end else if (!act[cfg_ch]) begin
          case (cfg_sel)
            4'd0: sa[cfg_ch]  <= cfg_wdata[AW-1:0];
            4'd1: da[cfg_ch]  <= cfg_wdata[AW-1:0];
            4'd2: so[cfg_ch]  <= cfg_wdata[15:0];
            4'd3: dof[cfg_ch] <= cfg_wdata[15:0];
            4'd4: begin ssz[cfg_ch] <= cfg_wdata[1:0]; dsz[cfg_ch] <= cfg_wdata[3:2]; end
            4'd5: nb[cfg_ch]  <= cfg_wdata[NW-1:0];
            4'd6: begin cit[cfg_ch] <= cfg_wdata[IW-1:0]; bit_q[cfg_ch] <= cfg_wdata[16+IW-1:16]; end
            4'd7: sl[cfg_ch]  <= cfg_wdata[AW-1:0];
            4'd8: dl[cfg_ch]  <= cfg_wdata[AW-1:0];
            4'd9: begin
              ie[cfg_ch] <= cfg_wdata[1];
              if (cfg_wdata[0]) begin
                if (cfg_ok) begin st[cfg_ch] <= 1'b1; er[cfg_ch] <= 1'b0; end
                else er[cfg_ch] <= 1'b1;
              end
            end
            default: ;
          endcase
        end
      end

      case (state)
        S_IDLE: if (found) begin
          st[gnt]  <= 1'b0;
          dn[gnt]  <= 1'b0;
          act[gnt] <= 1'b1;
          cur      <= gnt;
          rr_last  <= gnt;
          state    <= S_LOAD;
        end
        S_LOAD: begin
          wsa   <= sa[cur];
          wda   <= da[cur];
          left  <= nb[cur];
          pos   <= '0;
          state <= S_RD;
        end
        S_RD: if (m_ready) begin
          buff <= buf_nx;
          wsa  <= wsa + soff_x;
          if (pos + sb == chk) begin pos <= '0; state <= S_WR; end
          else pos <= pos + sb;
        end
        S_WR: if (m_ready) begin
          wda <= wda + doff_x;
          if (pos + db == chk) begin
            pos   <= '0;
            left  <= left - NW'(chk);
            state <= (left == NW'(chk)) ? S_FIN : S_RD;
          end else pos <= pos + db;
        end
        S_FIN: begin
          if (cit[cur] <= IW'(1)) begin
            cit[cur] <= bit_q[cur];
            sa[cur]  <= wsa + sl[cur];
            da[cur]  <= wda + dl[cur];
            dn[cur]  <= 1'b1;
            if (ie[cur]) ip[cur] <= 1'b1;
          end else begin
            cit[cur] <= cit[cur] - IW'(1);
            sa[cur]  <= wsa;
            da[cur]  <= wda;
          end
          act[cur] <= 1'b0;
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_single_active_r2: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(act));

  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_addr) && $stable(m_write) &&
                            $stable(m_size) && $stable(m_wdata));

  p_bus_needs_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> (act != '0));

  for (genvar k = 0; k < NCH; k++) begin : g_chk
    p_done_closes_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dn[k]) |-> $fell(act[k]));
    p_irq_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ip[k]) |-> $rose(dn[k]));
    p_refused_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(er[k]) |-> !st[k]);
    p_locked_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we && cfg_ch == CW'(k) && cfg_sel == 4'd2 && act[k] |=> $stable(so[k]));
  end
endmodule

// File: tb/xfer_engine_tb.sv
module xfer_engine_tb_top;
  localparam int PERIOD = 10;
  localparam int LAT = 1;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [1:0] cfg_ch = 0, rd_ch = 0;
  logic [3:0] cfg_sel = 0, rd_sel = 0;
  logic [31:0] cfg_wdata = 0, rd_data;
  logic m_valid, m_write, m_ready = 0;
  logic [31:0] m_addr, m_wdata, m_rdata = 0;
  logic [1:0] m_size;
  logic [3:0] ch_active, ch_done;
  logic irq;

  logic [7:0] mem [256];
  logic [31:0] wlog_a [64];
  logic [31:0] wlog_d [64];
  int n_wr = 0, n_acc = 0, wcnt = 0;
  bit hold_mem = 0;
  int n_chk = 0, n_fail = 0;
  bit ended = 0;

  always #(PERIOD/2) clk = ~clk;

  xfer_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .rd_ch(rd_ch), .rd_sel(rd_sel), .rd_data(rd_data),
    .m_valid(m_valid), .m_write(m_write), .m_addr(m_addr), .m_size(m_size),
    .m_wdata(m_wdata), .m_ready(m_ready), .m_rdata(m_rdata),
    .ch_active(ch_active), .ch_done(ch_done), .irq(irq));

  always @(negedge clk) begin
    if (!rst_n) begin
      m_ready <= 0; wcnt = 0;
    end else if (m_ready) begin
      m_ready <= 0;
    end else if (m_valid && !hold_mem) begin
      if (wcnt == LAT) begin
        wcnt = 0;
        m_ready <= 1;
        n_acc++;
        if (m_write) begin
          for (int j = 0; j < (1 << m_size); j++)
            mem[8'(m_addr + 32'(j))] = m_wdata[j*8 +: 8];
          if (n_wr < 64) begin wlog_a[n_wr] = m_addr; wlog_d[n_wr] = m_wdata; end
          n_wr++;
        end else begin
          logic [31:0] r;
          r = 0;
          for (int j = 0; j < (1 << m_size); j++) r[j*8 +: 8] = mem[8'(m_addr + 32'(j))];
          m_rdata <= r;
        end
      end else wcnt++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] a, input logic [31:0] e);
    n_chk++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  task automatic wr(input int ch, input int sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_ch = 2'(ch); cfg_sel = 4'(sel); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic rd(input int ch, input int sel, output logic [31:0] d);
    rd_ch = 2'(ch); rd_sel = 4'(sel);
    #1 d = rd_data;
  endtask

  task automatic setup(input int ch, input logic [31:0] s, input logic [31:0] d,
                       input logic [15:0] so, input logic [15:0] dof, input int ss, input int ds,
                       input int nb, input int it, input logic [31:0] slst, input logic [31:0] dlst);
    wr(ch, 0, s); wr(ch, 1, d); wr(ch, 2, {16'd0, so}); wr(ch, 3, {16'd0, dof});
    wr(ch, 4, 32'((ds << 2) | ss)); wr(ch, 5, 32'(nb)); wr(ch, 6, {16'(it), 16'(it)});
    wr(ch, 7, slst); wr(ch, 8, dlst);
  endtask

  task automatic wait_quiet();
    logic [31:0] c;
    bit busy;
    repeat (3) @(negedge clk);
    for (int t = 0; t < 5000; t++) begin
      busy = (ch_active != 0);
      for (int k = 0; k < 4; k++) begin rd(k, 9, c); if (c[0]) busy = 1; end
      if (!busy) break;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 reset active", 32'(ch_active), 0);
    chk("R10 reset irq", 32'(irq), 0);
    chk("R7 reset valid", 32'(m_valid), 0);
    rd(0, 9, v); chk("R1 reset ctrl", v, 0);
    rd(3, 0, v); chk("R1 reset src ptr", v, 0);
  endtask

  task automatic t_readback();
    logic [31:0] v;
    wr(2, 0, 32'h1234_5678); wr(2, 2, 32'h0000_FFFC); wr(2, 6, 32'h0005_0003);
    rd(2, 0, v); chk("R1 readback src", v, 32'h1234_5678);
    rd(2, 2, v); chk("R1 readback step", v, 32'h0000_FFFC);
    rd(2, 6, v); chk("R1 readback iter", v, 32'h0005_0003);
  endtask

  task automatic t_pack();
    logic [31:0] v;
    bit ok;
    int base;
    for (int i = 0; i < 16; i++) mem[8'h10 + i] = 8'hA0 + 8'(i);
    setup(0, 32'h10, 32'h40, 16'd1, 16'd4, 0, 2, 16, 1, -32'sd16, -32'sd16);
    base = n_wr;
    wr(0, 9, 32'h3);
    wait_quiet();
    ok = 1;
    for (int i = 0; i < 16; i++) if (mem[8'h40 + i] !== 8'hA0 + 8'(i)) ok = 0;
    chk("R4 packed copy", 32'(ok), 1);
    chk("R4 write count", 32'(n_wr - base), 4);
    chk("R4 lane order", wlog_d[base], 32'hA3A2_A1A0);
    chk("R6 dest step", wlog_a[base+1], 32'h44);
    rd(0, 0, v); chk("R9 src last-adjust", v, 32'h10);
    rd(0, 1, v); chk("R9 dst last-adjust", v, 32'h40);
    rd(0, 6, v); chk("R9 iter reload", v, 32'h0001_0001);
    rd(0, 9, v); chk("R10 ctrl done+irq", v, 32'h2A);
    chk("R10 irq level", 32'(irq), 1);
    repeat (4) @(negedge clk);
    chk("R10 irq sticky", 32'(irq), 1);
    wr(0, 10, 32'h1);
    chk("R10 irq cleared", 32'(irq), 0);
  endtask

  task automatic t_split();
    logic [31:0] v;
    bit ok;
    for (int i = 0; i < 16; i++) mem[8'h80 + i] = 8'h30 + 8'(i);
    setup(1, 32'h80, 32'hCF, 16'd4, 16'hFFFF, 2, 0, 8, 2, 0, 0);
    wr(1, 9, 32'h1);
    wait_quiet();
    ok = 1;
    for (int i = 0; i < 8; i++) if (mem[8'hCF - i] !== 8'h30 + 8'(i)) ok = 0;
    chk("R5 split descending copy", 32'(ok), 1);
    rd(1, 0, v); chk("R8 src writeback", v, 32'h88);
    rd(1, 1, v); chk("R6 negative step writeback", v, 32'hC7);
    rd(1, 6, v); chk("R8 iter decrement", v, 32'h0002_0001);
    rd(1, 9, v); chk("R8 not done mid job", v, 32'h0);
    wr(1, 9, 32'h1);
    wait_quiet();
    ok = 1;
    for (int i = 0; i < 8; i++) if (mem[8'hC7 - i] !== 8'h38 + 8'(i)) ok = 0;
    chk("R5 second iteration copy", 32'(ok), 1);
    rd(1, 0, v); chk("R9 src final", v, 32'h90);
    rd(1, 1, v); chk("R9 dst final", v, 32'hBF);
    rd(1, 6, v); chk("R9 reload", v, 32'h0002_0002);
    rd(1, 9, v); chk("R10 done without enable", v, 32'h08);
    chk("R10 no irq when disabled", 32'(irq), 0);
  endtask

  task automatic t_cfg_err();
    logic [31:0] v;
    int acc0;
    setup(3, 32'h10, 32'h60, 16'd1, 16'd4, 0, 2, 6, 1, 0, 0);
    acc0 = n_acc;
    wr(3, 9, 32'h1);
    repeat (6) @(negedge clk);
    rd(3, 9, v); chk("R11 refused start", v, 32'h10);
    chk("R11 no bus traffic", 32'(n_acc - acc0), 0);
    chk("R11 not active", 32'(ch_active), 0);
    wr(3, 5, 32'd8);
    wr(3, 9, 32'h1);
    wait_quiet();
    rd(3, 9, v); chk("R11 error cleared on good start", v, 32'h08);
  endtask

  task automatic t_locked();
    logic [31:0] v;
    setup(2, 32'h10, 32'h50, 16'd1, 16'd1, 0, 0, 16, 1, 0, 0);
    wr(2, 9, 32'h1);
    @(negedge clk);
    wr(2, 0, 32'h99);
    wr(2, 2, 32'h5);
    wr(0, 0, 32'h77);
    wait_quiet();
    rd(2, 0, v); chk("R12 blocked src ptr", v, 32'h20);
    rd(2, 2, v); chk("R12 blocked step", v, 32'h1);
    rd(0, 0, v); chk("R12 other channel writable", v, 32'h77);
  endtask

  task automatic t_rr();
    logic [31:0] v;
    int base;
    for (int k = 0; k < 4; k++)
      setup(k, 32'h10 + 32'(k), 32'hE0 + 32'(k), 16'd1, 16'd1, 0, 0, 1, 1, 0, 0);
    hold_mem = 1;
    base = n_wr;
    wr(1, 9, 32'h1);
    repeat (2) @(negedge clk);
    rd(1, 9, v); chk("R2 grant clears start/done sets active", v, 32'h04);
    wr(0, 9, 32'h1); wr(2, 9, 32'h1); wr(3, 9, 32'h1);
    rd(0, 9, v); chk("R2 pending start kept", v, 32'h09);
    hold_mem = 0;
    wait_quiet();
    chk("R3 grant 1", wlog_a[base], 32'hE1);
    chk("R3 grant 2", wlog_a[base+1], 32'hE0);
    chk("R3 grant 3", wlog_a[base+2], 32'hE3);
    chk("R3 grant 4", wlog_a[base+3], 32'hE2);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_pack();
    t_split();
    t_cfg_err();
    t_locked();
    t_rr();
    finish_run();
  end

  initial begin
    #(PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end
endmodule